// File: doc/BRIEF.md
# Message-signalled interrupt vector table with pending bits

This block is the device side of an extended message-signalled interrupt unit. It holds one table entry per vector: a 64-bit message address, a 32-bit message data word and a vector control word whose bit 0 masks that vector. It also holds a pending-bit array with one bit per vector. Software reaches both through a memory-mapped access port that takes 32-bit and 64-bit reads and writes. A separate select line picks the region.

Device logic raises interrupt requests as single-cycle pulses, one line per vector. When a request cannot be delivered, the block keeps a pending bit for that vector and sends no message. This happens when the vector is masked, when the whole function is masked, or when the function is not enabled. A pending vector is delivered later, when it is unmasked. The unmask can come from clearing the vector's own mask bit, or from clearing the function mask, which sweeps through all vectors. Messages leave on a valid/ready port that carries the address, the data and the vector index.

Top module: `msix_ctrl`

## Requirements
- R1: Table access by 32-bit word uses entry index = offset/16. Within the entry, byte 0x0 is address low, 0x4 is address high, 0x8 is message data and 0xC is vector control. Reads return the stored word in bits 31:0 with zeros above.
- R2: After reset, every entry has vector control 1 and address and data 0, every pending bit is 0, and msg_valid_o is 0.
- R3: A 64-bit table access at entry byte 0x0 covers {address high, address low}, with low in bits 31:0. At 0x8 it covers {vector control, data}, with data in bits 31:0. A 64-bit access at any other alignment reads 0 and a write there changes nothing.
- R4: A pending-array read selects the 64-bit word offset/8, which holds vectors 64*word to 64*word+63 with the lowest vector in bit 0. A 32-bit read at word byte 0 returns bits 31:0, and at byte 4 returns bits 63:32. A 64-bit read at byte 0 returns the whole word. Writes to the pending array are ignored.
- R5: The function is live when fn_enable_i=1 and fn_mask_i=0. A request is masked when its vector has control bit 0 set or the function is not live. A masked request sets the vector's pending bit and produces no message.
- R6: A request on a vector that is not masked produces one message with that entry's address, data and vector index, and leaves the pending bit clear.
- R7: A table write that changes a vector's mask bit from 1 to 0 while the function is live sends that vector's message and clears its pending bit, if the bit was set. If the pending bit was clear, the write sends nothing.
- R8: When fn_mask_i falls while fn_enable_i=1, every vector that is pending and not individually masked is sent once, in ascending index order, and its pending bit is cleared. Pending vectors that are individually masked keep their bit.
- R9: While msg_valid_o=1 and msg_ready_i=0, the message stays valid and its address, data and index do not change.
- R10: A table read that is misaligned or lies past the last entry returns 0, as does a pending-array read past the last word. Writes to such offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Register access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_pba_i | input | 1 | 1 = pending array region, 0 = vector table region |
| acc_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr_i | input | ADDR_W | Byte offset within the selected region |
| acc_wdata_i | input | 64 | Write data (bits 31:0 for 32-bit writes) |
| acc_rdata_o | output | 64 | Read data, registered, valid the cycle after the read strobe |
| fn_mask_i | input | 1 | Function-wide mask |
| fn_enable_i | input | 1 | Function enable |
| irq_i | input | NUM_VEC | Per-vector request pulses |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message accepted |
| msg_addr_o | output | 64 | Message address |
| msg_data_o | output | 32 | Message data |
| msg_vec_o | output | VW | Vector index of the message |

## Verification
The bench builds the block with 70 vectors and a 12-bit offset. This gives the pending array two words, and the second word is only partly populated. It can then check reads of the upper word, of the empty upper half, and of the word past the end, along with table offsets just beyond entry 69. The sweep covers vectors on both sides of the 64-bit word boundary, so its ascending order is checked across words. Messages are also held under back-pressure.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [31:0] data;
    logic [31:0] ctl;
  } vec_entry_t;

  localparam logic [3:0] OFS_LO   = 4'h0;
  localparam logic [3:0] OFS_HI   = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;
  localparam logic [3:0] OFS_CTL  = 4'hC;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 16,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              acc_pba_i,
  input  logic              acc_wide_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [63:0]       acc_wdata_i,
  output logic [63:0]       rdata_o,
  output logic [NUM_VEC-1:0] vmask_o,
  output logic              unmask_stb_o,
  output logic [VW-1:0]     unmask_idx_o,
  input  logic [VW-1:0]     pick_idx_i,
  output logic [63:0]       pick_addr_o,
  output logic [31:0]       pick_data_o
);
  localparam logic [ADDR_W-1:0] TBL_END = ADDR_W'(NUM_VEC * 16);

  vec_entry_t ent_q [NUM_VEC];
  vec_entry_t cur;
  logic          idx_ok, wr_en, ctl_hit, new_mask;
  logic [VW-1:0] idx_s;
  logic [3:0]    sub;

  assign sub    = acc_addr_i[3:0];
  assign idx_ok = acc_addr_i < TBL_END;
  assign idx_s  = idx_ok ? acc_addr_i[VW+3:4] : '0;
  assign cur    = ent_q[idx_s];
  assign wr_en  = acc_valid_i && acc_write_i && !acc_pba_i && idx_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int v = 0; v < NUM_VEC; v++) ent_q[v] <= '{addr_lo: '0, addr_hi: '0, data: '0, ctl: 32'd1};
    end else if (wr_en) begin
      if (!acc_wide_i) begin
        case (sub)
          OFS_LO:   ent_q[idx_s].addr_lo <= acc_wdata_i[31:0];
          OFS_HI:   ent_q[idx_s].addr_hi <= acc_wdata_i[31:0];
          OFS_DATA: ent_q[idx_s].data    <= acc_wdata_i[31:0];
          OFS_CTL:  ent_q[idx_s].ctl     <= acc_wdata_i[31:0];
          default: ;
        endcase
      end else begin
        case (sub)
          OFS_LO: begin
            ent_q[idx_s].addr_lo <= acc_wdata_i[31:0];
            ent_q[idx_s].addr_hi <= acc_wdata_i[63:32];
          end
          OFS_DATA: begin
            ent_q[idx_s].data <= acc_wdata_i[31:0];
            ent_q[idx_s].ctl  <= acc_wdata_i[63:32];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_ok) begin
      if (acc_wide_i) begin
        case (sub)
          OFS_LO:   rdata_o = {cur.addr_hi, cur.addr_lo};
          OFS_DATA: rdata_o = {cur.ctl, cur.data};
          default:  rdata_o = '0;
        endcase
      end else begin
        case (sub)
          OFS_LO:   rdata_o = {32'd0, cur.addr_lo};
          OFS_HI:   rdata_o = {32'd0, cur.addr_hi};
          OFS_DATA: rdata_o = {32'd0, cur.data};
          OFS_CTL:  rdata_o = {32'd0, cur.ctl};
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  // mask 1 -> 0 edge on a control word write
  assign ctl_hit      = wr_en && (acc_wide_i ? (sub == OFS_DATA) : (sub == OFS_CTL));
  assign new_mask     = acc_wide_i ? acc_wdata_i[32] : acc_wdata_i[0];
  assign unmask_stb_o = ctl_hit && cur.ctl[0] && !new_mask;
  assign unmask_idx_o = idx_s;

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) vmask_o[v] = ent_q[v].ctl[0];
  end

  assign pick_addr_o = {ent_q[pick_idx_i].addr_hi, ent_q[pick_idx_i].addr_lo};
  assign pick_data_o = ent_q[pick_idx_i].data;
endmodule

// File: rtl/msix_pba.sv
module msix_pba #(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 16,
  localparam int VW    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int NWORD = NUM_VEC / 64 + 1,
  localparam int PADW  = NWORD * 64,
  localparam int WW    = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               acc_wide_i,
  output logic [63:0]        rdata_o,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic [NUM_VEC-1:0] vmask_i,
  input  logic               live_i,
  input  logic               sweep_i,
  input  logic               unmask_stb_i,
  input  logic [VW-1:0]      unmask_idx_i,
  input  logic               take_i,
  input  logic               send_i,
  input  logic [VW-1:0]      sel_idx_i,
  output logic [NUM_VEC-1:0] fire_o
);
  localparam logic [ADDR_W-1:0] PBA_END = ADDR_W'(NWORD * 8);

  logic [NUM_VEC-1:0] pend_q, fire_q, pend_d, fire_d;
  logic [PADW-1:0]    pad;
  logic [63:0]        word;
  logic [WW-1:0]      wsel;
  logic               ok;

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      logic hit_sel, hit_un, set_f;
      hit_sel = sel_idx_i == VW'(v);
      hit_un  = unmask_stb_i && (unmask_idx_i == VW'(v));
      set_f   = (irq_i[v] && live_i && !vmask_i[v])
             || (hit_un && live_i && pend_q[v])
             || (sweep_i && pend_q[v] && !vmask_i[v]);
      pend_d[v] = (pend_q[v] && !(send_i && hit_sel)) || irq_i[v];
      fire_d[v] = (fire_q[v] && !(take_i && hit_sel)) || set_f;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      fire_q <= '0;
    end else begin
      pend_q <= pend_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o  = fire_q;
  assign pad     = {{(PADW-NUM_VEC){1'b0}}, pend_q};
  assign ok      = acc_addr_i < PBA_END;
  assign wsel    = ok ? acc_addr_i[WW+2:3] : '0;
  assign word    = pad[wsel*64 +: 64];

  always_comb begin
    rdata_o = '0;
    if (ok) begin
      if (acc_wide_i) rdata_o = (acc_addr_i[2:0] == 3'd0) ? word : '0;
      else if (acc_addr_i[2:0] == 3'd0) rdata_o = {32'd0, word[31:0]};
      else if (acc_addr_i[2:0] == 3'd4) rdata_o = {32'd0, word[63:32]};
    end
  end

  // R5
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));
  // R7
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && !irq_i[sel_idx_i]) |=> !pend_q[$past(sel_idx_i)]);
endmodule

// File: rtl/msix_issue.sv
module msix_issue #(
  parameter int NUM_VEC = 16,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] fire_i,
  input  logic [NUM_VEC-1:0] vmask_i,
  input  logic               live_i,
  input  logic [63:0]        pick_addr_i,
  input  logic [31:0]        pick_data_i,
  output logic [VW-1:0]      sel_idx_o,
  output logic               take_o,
  output logic               send_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [VW-1:0]      msg_vec_o
);
  logic any, slot_free;

  // lowest index wins
  always_comb begin
    sel_idx_o = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) if (fire_i[v]) sel_idx_o = VW'(v);
  end

  assign any       = |fire_i;
  assign slot_free = !msg_valid_o || msg_ready_i;
  assign take_o    = any && slot_free;
  // drop without sending if the vector was re-masked in the meantime
  assign send_o    = take_o && live_i && !vmask_i[sel_idx_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
      msg_vec_o   <= '0;
    end else if (send_o) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= pick_addr_i;
      msg_data_o  <= pick_data_i;
      msg_vec_o   <= sel_idx_o;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_addr_o)
                                       && $stable(msg_data_o) && $stable(msg_vec_o)));
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl #(
  parameter int NUM_VEC = 16,
  parameter int ADDR_W  = 16,
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic               acc_write_i,
  input  logic               acc_pba_i,
  input  logic               acc_wide_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [63:0]        acc_wdata_i,
  output logic [63:0]        acc_rdata_o,
  input  logic               fn_mask_i,
  input  logic               fn_enable_i,
  input  logic [NUM_VEC-1:0] irq_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [63:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [VW-1:0]      msg_vec_o
);
  localparam logic [ADDR_W-1:0] TBL_END = ADDR_W'(NUM_VEC * 16);

  logic [63:0]        tbl_rd, pba_rd, pick_addr;
  logic [31:0]        pick_data;
  logic [NUM_VEC-1:0] vmask, fire;
  logic               unmask_stb, take, send, live, sweep, fm_q;
  logic [VW-1:0]      unmask_idx, sel_idx;

  assign live  = fn_enable_i && !fn_mask_i;
  assign sweep = fm_q && !fn_mask_i && fn_enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fm_q        <= 1'b1;
      acc_rdata_o <= '0;
    end else begin
      fm_q <= fn_mask_i;
      if (acc_valid_i && !acc_write_i) acc_rdata_o <= acc_pba_i ? pba_rd : tbl_rd;
    end
  end

  msix_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_table (
    .clk_i, .rst_ni, .acc_valid_i, .acc_write_i, .acc_pba_i, .acc_wide_i,
    .acc_addr_i, .acc_wdata_i,
    .rdata_o(tbl_rd), .vmask_o(vmask),
    .unmask_stb_o(unmask_stb), .unmask_idx_o(unmask_idx),
    .pick_idx_i(sel_idx), .pick_addr_o(pick_addr), .pick_data_o(pick_data)
  );

  msix_pba #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_pba (
    .clk_i, .rst_ni, .acc_addr_i, .acc_wide_i,
    .rdata_o(pba_rd), .irq_i, .vmask_i(vmask), .live_i(live), .sweep_i(sweep),
    .unmask_stb_i(unmask_stb), .unmask_idx_i(unmask_idx),
    .take_i(take), .send_i(send), .sel_idx_i(sel_idx), .fire_o(fire)
  );

  msix_issue #(.NUM_VEC(NUM_VEC)) u_issue (
    .clk_i, .rst_ni, .fire_i(fire), .vmask_i(vmask), .live_i(live),
    .pick_addr_i(pick_addr), .pick_data_i(pick_data),
    .sel_idx_o(sel_idx), .take_o(take), .send_o(send),
    .msg_valid_o, .msg_ready_i, .msg_addr_o, .msg_data_o, .msg_vec_o
  );

  // R10
  bad_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i && !acc_pba_i && (acc_addr_i >= TBL_END)) |=> (acc_rdata_o == '0));
endmodule

// File: tb/msix_ctrl_test.sv
module msix_ctrl_test;
  localparam int NV = 70;
  localparam int AW = 12;
  localparam int VW = $clog2(NV);

  logic           clk = 0, rst_n = 0;
  logic           acc_valid = 0, acc_write = 0, acc_pba = 0, acc_wide = 0;
  logic [AW-1:0]  acc_addr = '0;
  logic [63:0]    acc_wdata = '0, acc_rdata;
  logic           fn_mask = 1, fn_en = 0;
  logic [NV-1:0]  irq = '0;
  logic           msg_valid, msg_ready = 1;
  logic [63:0]    msg_addr;
  logic [31:0]    msg_data;
  logic [VW-1:0]  msg_vec;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct { int vec; logic [63:0] addr; logic [31:0] data; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  msix_ctrl #(.NUM_VEC(NV), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_pba_i(acc_pba), .acc_wide_i(acc_wide), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata), .fn_mask_i(fn_mask),
    .fn_enable_i(fn_en), .irq_i(irq), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data), .msg_vec_o(msg_vec)
  );

  function automatic logic [31:0] v_lo(int v);   return 32'hFEE0_0000 | 32'(v << 4); endfunction
  function automatic logic [31:0] v_hi(int v);   return 32'h0000_A000 + 32'(v); endfunction
  function automatic logic [31:0] v_data(int v); return 32'h0000_4100 + 32'(v); endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit pba, input bit wr, input bit wide, input int a,
                     input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    acc_valid = 1; acc_pba = pba; acc_write = wr; acc_wide = wide;
    acc_addr = AW'(a); acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    rd = acc_rdata;
  endtask

  task automatic rd_chk(input bit pba, input bit wide, input int a, input logic [63:0] exp, input string req);
    logic [63:0] r;
    acc(pba, 0, wide, a, '0, r);
    chk(r == exp, req, r, exp);
  endtask

  task automatic wr(input bit pba, input bit wide, input int a, input logic [63:0] wd);
    logic [63:0] r;
    acc(pba, 1, wide, a, wd, r);
  endtask

  task automatic expect_msg(input int v);
    exp_q.push_back('{vec: v, addr: {v_hi(v), v_lo(v)}, data: v_data(v)});
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    @(negedge clk); irq = m;
    @(negedge clk); irq = '0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R6 unexpected message actual vec=%0d expected none", msg_vec);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(msg_vec == VW'(e.vec) && msg_addr == e.addr && msg_data == e.data,
            "R6/R8 message", {25'd0, msg_vec, msg_data}, {25'd0, VW'(e.vec), e.data});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk(msg_valid == 0, "R2 msg_valid", 64'(msg_valid), 0);
    rd_chk(0, 0, 12'h00C, 64'd1, "R2 ctl v0");
    rd_chk(0, 0, 69 * 16 + 12, 64'd1, "R2 ctl v69");
    rd_chk(0, 0, 5 * 16 + 4, 64'd0, "R2 addr_hi v5");
    rd_chk(1, 1, 0, 64'd0, "R2 pba word0");

    for (int v = 0; v < NV; v++) begin
      wr(0, 1, v * 16, {v_hi(v), v_lo(v)});
      wr(0, 0, v * 16 + 8, {32'd0, v_data(v)});
    end
    // R1 narrow fields
    rd_chk(0, 0, 3 * 16 + 0, {32'd0, v_lo(3)}, "R1 lo");
    rd_chk(0, 0, 3 * 16 + 4, {32'd0, v_hi(3)}, "R1 hi");
    rd_chk(0, 0, 3 * 16 + 8, {32'd0, v_data(3)}, "R1 data");
    rd_chk(0, 0, 68 * 16 + 8, {32'd0, v_data(68)}, "R1 data v68");
    // R3 wide
    rd_chk(0, 1, 3 * 16, {v_hi(3), v_lo(3)}, "R3 wide addr");
    rd_chk(0, 1, 3 * 16 + 8, {32'd1, v_data(3)}, "R3 wide ctl:data");
    rd_chk(0, 1, 3 * 16 + 4, 64'd0, "R3 misaligned wide read");
    wr(0, 1, 3 * 16 + 4, 64'hDEAD_BEEF_DEAD_BEEF);
    rd_chk(0, 1, 3 * 16, {v_hi(3), v_lo(3)}, "R3 misaligned wide write ignored");
    rd_chk(0, 0, 3 * 16 + 8, {32'd0, v_data(3)}, "R3 misaligned write data kept");
    // R10 invalid offsets
    rd_chk(0, 0, 3 * 16 + 2, 64'd0, "R10 misaligned narrow");
    wr(0, 0, 3 * 16 + 6, 64'h1234);
    rd_chk(0, 0, 3 * 16 + 4, {32'd0, v_hi(3)}, "R10 misaligned write ignored");
    rd_chk(0, 0, NV * 16, 64'd0, "R10 past table");
    rd_chk(1, 0, 16, 64'd0, "R10 past pba");

    // R5 masked by function mask and disable
    pulse(NV'(1) << 2);
    repeat (3) @(negedge clk);
    rd_chk(1, 0, 0, 64'h4, "R5 pending set fn masked");
    fn_en = 1;
    wr(0, 0, 2 * 16 + 12, 64'd0);
    wr(0, 0, 5 * 16 + 12, 64'd0);
    wr(0, 0, 66 * 16 + 12, 64'd0);
    pulse((NV'(1) << 5) | (NV'(1) << 66) | (NV'(1) << 10));
    repeat (3) @(negedge clk);
    rd_chk(1, 0, 0, 64'h424, "R5 pending word0");
    rd_chk(1, 0, 8, 64'h4, "R4 pending word1 low");
    rd_chk(1, 0, 12, 64'h0, "R4 pending word1 high");
    rd_chk(1, 1, 8, 64'h4, "R4 pending word1 wide");
    wr(1, 0, 0, 64'hFFFF_FFFF);
    rd_chk(1, 1, 0, 64'h424, "R4 pending write ignored");

    // R8 sweep on function unmask, ascending across words
    expect_msg(2); expect_msg(5); expect_msg(66);
    @(negedge clk); fn_mask = 0;
    drain("R8 sweep");
    rd_chk(1, 1, 0, 64'h400, "R8 masked pending kept");
    rd_chk(1, 1, 8, 64'h0, "R8 pending cleared");

    // R6 live requests
    expect_msg(5);
    pulse(NV'(1) << 5);
    drain("R6 single");
    expect_msg(2); expect_msg(66);
    pulse((NV'(1) << 66) | (NV'(1) << 2));
    drain("R6 pair");
    rd_chk(1, 1, 0, 64'h400, "R6 no pending left");

    // R7 per-vector unmask
    expect_msg(10);
    wr(0, 0, 10 * 16 + 12, 64'd0);
    drain("R7 unmask pending");
    rd_chk(1, 1, 0, 64'h0, "R7 pending cleared");
    wr(0, 0, 20 * 16 + 12, 64'd0);
    drain("R7 unmask no pending");
    pulse(NV'(1) << 11);
    repeat (3) @(negedge clk);
    rd_chk(1, 1, 0, 64'h800, "R5 entry masked pending");
    expect_msg(11);
    wr(0, 1, 11 * 16 + 8, {32'd0, v_data(11)});
    drain("R7 wide unmask");

    // R5 disabled, unmasked: pending only; then R7 re-mask/unmask delivers
    fn_en = 0;
    pulse(NV'(1) << 5);
    repeat (3) @(negedge clk);
    rd_chk(1, 1, 0, 64'h20, "R5 disabled pending");
    fn_en = 1;
    repeat (3) @(negedge clk);
    wr(0, 0, 5 * 16 + 12, 64'd1);
    expect_msg(5);
    wr(0, 0, 5 * 16 + 12, 64'd0);
    drain("R7 re-unmask");

    // R9 back-pressure
    @(negedge clk); msg_ready = 0;
    expect_msg(5);
    pulse(NV'(1) << 5);
    @(negedge clk);
    chk(msg_valid == 1 && msg_vec == VW'(5), "R9 held valid", {56'd0, 1'b0, msg_vec}, 64'd5);
    repeat (3) @(negedge clk);
    chk(msg_valid == 1 && msg_data == v_data(5), "R9 held stable", {32'd0, msg_data}, {32'd0, v_data(5)});
    msg_ready = 1;
    drain("R9 release");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule